// File: doc/BRIEF.md
# Programmable Range Chip-Select Decoder

This block maps one address onto four chip-select lines. Each line has its own inclusive address window, set by a lower bound and an upper bound. A line goes low whenever the address falls inside its window. The decision is made in combinational logic, so the chip-selects follow the address within the same cycle without waiting for a clock edge.

The bounds of all four windows live in registers. A synchronous reset loads them from parameters, and by default those parameters describe a small 16-bit memory map: a large RAM area, two small I/O areas, and an upper ROM half.

At run time, a single-cycle write port can replace any one bound. The four windows are independent of each other. They can overlap, and they can leave gaps. Where windows overlap, the block does not resolve priority: every window that contains the address drives its own line low.

Top module: `window_csel`

## Requirements
- R1: Each of the four active-low outputs `csN[k]` is low exactly when lowBound(k) <= `addr` <= highBound(k), comparing as unsigned numbers, with both bounds included.
- R2: A window programmed as 0x004C..0x0051 asserts for 0x004C, 0x004E and 0x0051, and stays high for 0x004B and 0x0052.
- R3: After reset with default parameters (16-bit address), window 0 covers 0x0000..0x6FFF, window 1 covers 0x7000..0x7003, window 2 covers 0x7004..0x7005, and window 3 covers 0x8000..0xFFFF.
- R4: Under the default map, every address in the gap 0x7006..0x7FFF leaves all four outputs high (`csN` = 4'hF).
- R5: Windows are decoded without priority. An address that lies in several overlapping windows drives all of their outputs low at once.
- R6: A window whose lower bound is greater than its upper bound never drives its output low.
- R7: While `rstN` is low at a rising clock edge, all eight bounds return to their parameter defaults. This discards any value written earlier.
- R8: A write with `cfgWe` high loads `cfgData` into one bound. `cfgSel[0]`=0 selects the lower bound and `cfgSel[0]`=1 selects the upper bound. `cfgSel[2:1]` gives the window index. No other bound changes.
- R9: While `cfgWe` is low, `cfgSel` and `cfgData` have no effect on any bound.
- R10: The outputs respond to `addr` in the same cycle. A written bound is used from the rising edge that captures the write onward, and it is not used before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bound registers |
| rstN | input | 1 | Synchronous reset, active low; loads the default bounds |
| addr | input | ADDR_W | Address to be decoded |
| cfgWe | input | 1 | Write strobe for a bound register |
| cfgSel | input | 3 | Selects the bound: bit 0 chooses lower (0) or upper (1), bits 2:1 choose the window |
| cfgData | input | ADDR_W | New value for the selected bound |
| csN | output | 4 | Active-low chip-selects, one per window |

## Verification
A corrupted or misdirected bound register appears at the ports only when an address crosses the affected edge of its window. For that reason the bench probes addresses on both sides of every programmed bound, right after each write. A write that lands in the wrong register, or that takes effect one cycle early or late, changes the chip-selects on the first probe after the capturing edge. The bench also checks the output just before that edge, to catch a write that takes effect too early. Reset faults show up on the first default-map probe after reset is released.

// File: rtl/window_csel_pkg.sv
package window_csel_pkg;
  localparam int NUM_WIN = 4;
  localparam int SEL_W = 3;
  localparam int IDX_W = SEL_W - 1;

  typedef struct packed {
    logic [NUM_WIN-1:0] lowWr;
    logic [NUM_WIN-1:0] highWr;
  } boundStrobe_t;
endpackage

// File: rtl/window_csel_ctrl.sv
module window_csel_ctrl
  import window_csel_pkg::*;
(
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  output boundStrobe_t     stb
);
  logic [IDX_W-1:0] winIdx;
  logic             pickHigh;

  assign winIdx   = cfgSel[SEL_W-1:1];
  assign pickHigh = cfgSel[0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_dec
    logic hitWin;
    assign hitWin = cfgWe && (winIdx == IDX_W'(w));
    assign stb.lowWr[w]  = hitWin && !pickHigh;
    assign stb.highWr[w] = hitWin && pickHigh;
  end
endmodule

// File: rtl/window_csel_dp.sv
module window_csel_dp
  import window_csel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] LOW_INIT  = '0,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] HIGH_INIT = '0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  boundStrobe_t                   stb,
  input  logic [ADDR_W-1:0]              wrData,
  input  logic [ADDR_W-1:0]              addr,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] lowQ,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] highQ,
  output logic [NUM_WIN-1:0]             csN
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lowQ[w] <= LOW_INIT[w];
      end else if (stb.lowWr[w]) begin
        lowQ[w] <= wrData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        highQ[w] <= HIGH_INIT[w];
      end else if (stb.highWr[w]) begin
        highQ[w] <= wrData;
      end
    end

    logic aboveLow, belowHigh;
    assign aboveLow  = (addr >= lowQ[w]);
    assign belowHigh = (addr <= highQ[w]);
    assign csN[w]    = ~(aboveLow & belowHigh);
  end
endmodule

// File: rtl/window_csel.sv
module window_csel
  import window_csel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOW0  = 'h0000,
  parameter logic [ADDR_W-1:0] HIGH0 = 'h6FFF,
  parameter logic [ADDR_W-1:0] LOW1  = 'h7000,
  parameter logic [ADDR_W-1:0] HIGH1 = 'h7003,
  parameter logic [ADDR_W-1:0] LOW2  = 'h7004,
  parameter logic [ADDR_W-1:0] HIGH2 = 'h7005,
  parameter logic [ADDR_W-1:0] LOW3  = 'h8000,
  parameter logic [ADDR_W-1:0] HIGH3 = 'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [3:0]        csN
);
  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] LOW_INIT  = {LOW3, LOW2, LOW1, LOW0};
  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] HIGH_INIT = {HIGH3, HIGH2, HIGH1, HIGH0};

  boundStrobe_t                   stb;
  logic [NUM_WIN-1:0][ADDR_W-1:0] lowQ;
  logic [NUM_WIN-1:0][ADDR_W-1:0] highQ;

  window_csel_ctrl ctrl_i (
    .cfgWe (cfgWe),
    .cfgSel(cfgSel),
    .stb   (stb)
  );

  window_csel_dp #(
    .ADDR_W   (ADDR_W),
    .LOW_INIT (LOW_INIT),
    .HIGH_INIT(HIGH_INIT)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(cfgData),
    .addr  (addr),
    .lowQ  (lowQ),
    .highQ (highQ),
    .csN   (csN)
  );
endmodule

// File: rtl/window_csel_chk.sv
module window_csel_chk
  import window_csel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] LOW_INIT  = '0,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] HIGH_INIT = '0
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [ADDR_W-1:0]              addr,
  input logic                           cfgWe,
  input logic [2:0]                     cfgSel,
  input logic [ADDR_W-1:0]              cfgData,
  input logic [3:0]                     csN,
  input logic [NUM_WIN-1:0][ADDR_W-1:0] lowQ,
  input logic [NUM_WIN-1:0][ADDR_W-1:0] highQ
);
  // R7
  reset_defaults_chk: assert property (@(posedge clk)
    !rstN |=> (lowQ == LOW_INIT) && (highQ == HIGH_INIT));

  // R9
  idle_port_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(lowQ) && $stable(highQ));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    // R1
    select_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      !csN[w] |-> (addr >= lowQ[w]) && (addr <= highQ[w]));

    // R6
    inverted_window_chk: assert property (@(posedge clk) disable iff (!rstN)
      (lowQ[w] > highQ[w]) |-> csN[w]);

    // R8
    low_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && cfgSel == {2'(w), 1'b0}) |=> lowQ[w] == $past(cfgData));

    // R8
    high_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && cfgSel == {2'(w), 1'b1}) |=> highQ[w] == $past(cfgData));
  end
endmodule

bind window_csel window_csel_chk #(
  .ADDR_W   (ADDR_W),
  .LOW_INIT (LOW_INIT),
  .HIGH_INIT(HIGH_INIT)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .cfgWe  (cfgWe),
  .cfgSel (cfgSel),
  .cfgData(cfgData),
  .csN    (csN),
  .lowQ   (lowQ),
  .highQ  (highQ)
);

// File: tb/window_csel_tb_top.sv
module window_csel_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic [3:0]  csN;

  int vecCnt = 0;
  int missCnt = 0;
  bit done = 1'b0;

  logic [15:0] mLow [4];
  logic [15:0] mHigh[4];

  window_csel dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgData(cfgData), .csN(csN)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] expCs(logic [15:0] a);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = !((a >= mLow[k]) && (a <= mHigh[k]));
    return r;
  endfunction

  task automatic loadDefaults();
    mLow[0] = 16'h0000; mHigh[0] = 16'h6FFF;
    mLow[1] = 16'h7000; mHigh[1] = 16'h7003;
    mLow[2] = 16'h7004; mHigh[2] = 16'h7005;
    mLow[3] = 16'h8000; mHigh[3] = 16'hFFFF;
  endtask

  task automatic compare(string req, logic [3:0] exp);
    vecCnt++;
    if (csN !== exp) begin
      missCnt++;
      $display("FAIL %s addr=%h csN=%b expected=%b", req, addr, csN, exp);
    end
  endtask

  task automatic probe(string req, logic [15:0] a);
    @(negedge clk);
    addr = a;
    #1;
    compare(req, expCs(a));
  endtask

  task automatic probeLit(string req, logic [15:0] a, logic [3:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    compare(req, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    loadDefaults();
  endtask

  // R8/R10: write one bound, check it is not used before the edge and is used after
  task automatic writeBound(logic [2:0] sel, logic [15:0] val, logic [15:0] probeAddr);
    @(negedge clk);
    addr = probeAddr;
    cfgWe = 1'b1; cfgSel = sel; cfgData = val;
    #1;
    compare("R10 before edge", expCs(probeAddr));
    @(posedge clk);
    #1;
    cfgWe = 1'b0;
    if (sel[0]) mHigh[sel[2:1]] = val; else mLow[sel[2:1]] = val;
    compare("R10 after edge", expCs(probeAddr));
  endtask

  task automatic testDefaults();
    probeLit("R3", 16'h0000, 4'b1110);
    probeLit("R3", 16'h6FFF, 4'b1110);
    probeLit("R3", 16'h7000, 4'b1101);
    probeLit("R3", 16'h7003, 4'b1101);
    probeLit("R3", 16'h7004, 4'b1011);
    probeLit("R3", 16'h7005, 4'b1011);
    probeLit("R3", 16'h8000, 4'b0111);
    probeLit("R3", 16'hFFFF, 4'b0111);
  endtask

  task automatic testGap();
    probeLit("R4", 16'h7006, 4'hF);
    probeLit("R4", 16'h7ABC, 4'hF);
    probeLit("R4", 16'h7FFF, 4'hF);
  endtask

  task automatic testSmallWindow();
    writeBound(3'b000, 16'h004C, 16'h004B);
    writeBound(3'b001, 16'h0051, 16'h0052);
    probeLit("R2", 16'h004B, 4'b1111);
    probeLit("R2", 16'h004C, 4'b1110);
    probeLit("R2", 16'h004E, 4'b1110);
    probeLit("R2", 16'h0051, 4'b1110);
    probeLit("R2", 16'h0052, 4'b1111);
    probe("R1", 16'h6FFF);
  endtask

  task automatic testOverlap();
    writeBound(3'b010, 16'h0040, 16'h004D);
    writeBound(3'b011, 16'h0050, 16'h004D);
    probeLit("R5", 16'h004D, 4'b1100);
    probeLit("R5", 16'h0045, 4'b1101);
    probe("R1", 16'h0051);
  endtask

  task automatic testInverted();
    writeBound(3'b100, 16'h9000, 16'h9000);
    writeBound(3'b101, 16'h8FFF, 16'h8FFF);
    probeLit("R6", 16'h8FFF, 4'b0111);
    probeLit("R6", 16'h9000, 4'b0111);
    probeLit("R6", 16'h7004, 4'b1111);
  endtask

  task automatic testIdlePort();
    @(negedge clk);
    cfgWe = 1'b0; cfgSel = 3'b110; cfgData = 16'hFFFF;
    repeat (2) @(negedge clk);
    cfgSel = 3'b111; cfgData = 16'h0000;
    @(negedge clk);
    probeLit("R9", 16'h8000, 4'b0111);
    probeLit("R9", 16'hFFFF, 4'b0111);
  endtask

  task automatic testSelect();
    writeBound(3'b111, 16'h8FFF, 16'h9000);
    probeLit("R8", 16'h9000, 4'b1111);
    probeLit("R8", 16'h8FFF, 4'b0111);
    probeLit("R8", 16'h004C, 4'b1100);
    probe("R8", 16'h0052);
  endtask

  task automatic testReset();
    doReset();
    probeLit("R7", 16'h004B, 4'b1110);
    probeLit("R7", 16'h9000, 4'b0111);
    probeLit("R7", 16'h7004, 4'b1011);
    probeLit("R7", 16'h7001, 4'b1101);
  endtask

  initial begin
    loadDefaults();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testDefaults();
    testGap();
    testSmallWindow();
    testOverlap();
    testInverted();
    testIdlePort();
    testSelect();
    testReset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      missCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end
endmodule